// File: doc/BRIEF.md
# Time-Aware Transmit Gate Sequencer

This block produces the per-priority transmit-allow mask for one Ethernet egress port. A list of gate commands sits in a command store split into two equal halves. Each command pairs a gate mask with an interval length. The interval is measured in transmit units reported by the MAC: one unit is a byte on a gigabit link and a nibble on a 10 or 100 Mb/s link. An external periodic timer sends a cycle-start pulse, and on each pulse the sequencer restarts the list from word 0 of the half that is currently active.

Software builds the next schedule in the idle half and points the buffer-select bit at it. The switch happens only at the following cycle start, so a running list is never changed part way through. A status bit reports which half is actually executing. Two sticky flags record faults. One is set when the list runs past the last word of its half. The other is set when a cycle-start pulse arrives while a timed command is still counting.

The controller has five states:
- `ST_OFF`: gating is off.
- `ST_ARMED`: gating is enabled and the sequencer waits for the first pulse.
- `ST_RUN`: a timed command is counting.
- `ST_END`: a zero-count command has ended the list.
- `ST_OVERRUN`: the list ran past the end of its half.

The named transitions are:
- *disable*: any state goes to `ST_OFF` when either enable is low.
- *enable*: `ST_OFF` goes to `ST_ARMED`.
- *start*: `ST_ARMED`, `ST_RUN`, `ST_END` or `ST_OVERRUN` goes to `ST_RUN`, or to `ST_END` if word 0 has a zero count.
- *step*: `ST_RUN` goes to `ST_RUN` when the next word is timed.
- *finish*: `ST_RUN` goes to `ST_END` when the next word has a zero count.
- *overrun*: `ST_RUN` goes to `ST_OVERRUN` when the last word of the half expires.

Top module: `tx_gate_sequencer`

## Requirements
- R1: A command word carries its gate mask in bits 7:0 and its count in bits 21:8. On the write port, address bit log2(HALF_DEPTH) selects the half (bit 6 with the defaults) and the lower bits select the word.
- R2: The allow mask is all ones one cycle after the global enable or the port enable goes low. It stays all ones after enabling until the first accepted cycle-start pulse.
- R3: A cycle-start pulse accepted while enabled, with the enables high for at least one cycle before it, loads word 0 of the selected half. Its mask appears on the output in the cycle after the pulse.
- R4: A command with count n ≥ 16 holds its mask for exactly n unit ticks, and the next word's mask appears after the n-th tick. Clock cycles without a tick do not change the mask.
- R5: A nonzero count below 16 is treated as 16 ticks.
- R6: A zero-count word ends the list. Its mask stays on the output, whatever ticks arrive, until the next cycle start.
- R7: A change of buffer select has no effect until the next accepted cycle start. The active-buffer status output reports the half that is executing.
- R8: In one-buffer mode, half 0 is executed and buffer select is ignored. The active-buffer status then reads 0.
- R9: When the last word of the half expires, the address-error flag is set. The flag stays set until reset, and the last mask is held until the next cycle start.
- R10: A cycle start that arrives while a timed command is counting sets the sticky count-error flag and restarts the list from word 0. A cycle start in the ended or overrun state sets no count error.
- R11: When a cycle start and a tick arrive in the same cycle, the cycle start wins and the tick is not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| glb_en | input | 1 | Global gating enable |
| port_en | input | 1 | Per-port gating enable |
| single_buf | input | 1 | One-buffer mode: only half 0 is used |
| buf_sel | input | 1 | Half requested for the next cycle |
| wr_en | input | 1 | Command write strobe |
| wr_addr | input | HALF_AW+1 | Command write address, top bit is the half |
| wr_data | input | CNT_W+MASK_W | Command word: count above, mask below |
| unit_tick | input | 1 | One transmit unit (byte or nibble) sent |
| cyc_start | input | 1 | Cycle-start pulse from the periodic timer |
| allow_mask | output | MASK_W | Per-priority transmit-allow mask |
| active_buf | output | 1 | Half currently executing |
| err_count | output | 1 | Sticky: cycle restarted during a timed command |
| err_addr | output | 1 | Sticky: list ran past the end of its half |

## Verification
The bench sets HALF_DEPTH to 8 and keeps the default mask width, count width and minimum count of 16. With the smaller half, a full list of minimum-length commands runs off the end of its half in 128 ticks, so the overrun path and its held mask can be reached inside a short directed scenario. The same setting moves the half-select address bit to bit 3, which checks that the address split follows the parameter. Counts of 3, 16, 20 and 100 cover the minimum clamp and the exact tick on which a mask changes.

// File: rtl/tgs_pkg.sv
package tgs_pkg;

    typedef enum logic [2:0] {
        ST_OFF,
        ST_ARMED,
        ST_RUN,
        ST_END,
        ST_OVERRUN
    } seq_state_e;

endpackage

// File: rtl/tgs_cmd_ram.sv
module tgs_cmd_ram #(
    parameter int ENTRY_W    = 22,
    parameter int HALF_DEPTH = 64,
    parameter int HALF_AW    = 6,
    parameter int RAM_AW     = 7
) (
    input  logic               clk,
    input  logic               wr_en,
    input  logic [RAM_AW-1:0]  wr_addr,
    input  logic [ENTRY_W-1:0] wr_data,
    input  logic [RAM_AW-1:0]  rd_addr,
    output logic [ENTRY_W-1:0] rd_data
);

    logic [ENTRY_W-1:0] half_q [2];

    for (genvar h = 0; h < 2; h++) begin : g_half
        logic [ENTRY_W-1:0] mem [HALF_DEPTH];

        always_ff @(posedge clk) begin
            if (wr_en && (wr_addr[HALF_AW] == 1'(h))) begin
                mem[wr_addr[HALF_AW-1:0]] <= wr_data;
            end
        end

        assign half_q[h] = mem[rd_addr[HALF_AW-1:0]];
    end

    assign rd_data = half_q[rd_addr[HALF_AW]];

endmodule

// File: rtl/tgs_buf_ctrl.sv
module tgs_buf_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic single_buf,
    input  logic buf_sel,
    input  logic swap,
    output logic next_half,
    output logic active_buf
);

    assign next_half = single_buf ? 1'b0 : buf_sel;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_buf <= 1'b0;
        end else if (swap) begin
            active_buf <= next_half;
        end
    end

endmodule

// File: rtl/tgs_seq_fsm.sv
module tgs_seq_fsm
    import tgs_pkg::*;
#(
    parameter int MASK_W     = 8,
    parameter int CNT_W      = 14,
    parameter int HALF_DEPTH = 64,
    parameter int MIN_CNT    = 16,
    parameter int HALF_AW    = 6,
    parameter int RAM_AW     = 7,
    parameter int ENTRY_W    = 22
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               enable,
    input  logic               cyc_start,
    input  logic               unit_tick,
    input  logic               next_half,
    input  logic               active_half,
    input  logic [ENTRY_W-1:0] rd_data,
    output logic [RAM_AW-1:0]  rd_addr,
    output logic               swap,
    output logic [MASK_W-1:0]  allow_mask,
    output logic               err_count,
    output logic               err_addr
);

    localparam logic [HALF_AW-1:0] LAST_IDX = HALF_AW'(HALF_DEPTH - 1);
    localparam logic [CNT_W-1:0]   FLOOR    = CNT_W'(MIN_CNT);

    seq_state_e state_q, state_d;

    logic [CNT_W-1:0]   cnt_q;
    logic [HALF_AW-1:0] addr_q;
    logic [MASK_W-1:0]  mask_q;
    logic               err_count_q, err_addr_q;

    logic [CNT_W-1:0]   raw_cnt, eff_cnt;
    logic [MASK_W-1:0]  raw_mask;
    logic [HALF_AW-1:0] rd_idx;
    logic               start_go, expire, at_last, load_word, to_overrun;

    // decode of the word presented by the command store
    assign raw_mask = rd_data[MASK_W-1:0];
    assign raw_cnt  = rd_data[ENTRY_W-1:MASK_W];
    assign eff_cnt  = ((raw_cnt != '0) && (raw_cnt < FLOOR)) ? FLOOR : raw_cnt;

    // events
    assign start_go   = enable && cyc_start && (state_q != ST_OFF);
    assign expire     = enable && !start_go && (state_q == ST_RUN)
                        && unit_tick && (cnt_q == CNT_W'(1));
    assign at_last    = (addr_q == LAST_IDX);
    assign to_overrun = expire && at_last;
    assign load_word  = start_go || (expire && !at_last);
    assign swap       = start_go;

    always_comb begin
        rd_idx  = start_go ? '0 : (addr_q + HALF_AW'(1));
        rd_addr = {(start_go ? next_half : active_half), rd_idx};
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (!enable) begin
            state_d = ST_OFF;
        end else begin
            unique case (state_q)
                ST_OFF: state_d = ST_ARMED;
                ST_ARMED, ST_END, ST_OVERRUN: begin
                    if (cyc_start) begin
                        state_d = (raw_cnt == '0) ? ST_END : ST_RUN;
                    end
                end
                ST_RUN: begin
                    if (load_word) begin
                        state_d = (raw_cnt == '0) ? ST_END : ST_RUN;
                    end else if (to_overrun) begin
                        state_d = ST_OVERRUN;
                    end
                end
                default: state_d = ST_OFF;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    // command datapath and sticky flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q       <= '0;
            addr_q      <= '0;
            mask_q      <= '1;
            err_count_q <= 1'b0;
            err_addr_q  <= 1'b0;
        end else begin
            if (load_word) begin
                cnt_q  <= eff_cnt;
                mask_q <= raw_mask;
                addr_q <= rd_idx;
            end else if (enable && (state_q == ST_RUN) && unit_tick && !to_overrun) begin
                cnt_q <= cnt_q - CNT_W'(1);
            end
            if (start_go && (state_q == ST_RUN)) begin
                err_count_q <= 1'b1;
            end
            if (to_overrun) begin
                err_addr_q <= 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        unique case (state_q)
            ST_RUN, ST_END, ST_OVERRUN: allow_mask = mask_q;
            default:                    allow_mask = '1;
        endcase
        err_count = err_count_q;
        err_addr  = err_addr_q;
    end

endmodule

// File: rtl/tx_gate_sequencer.sv
module tx_gate_sequencer #(
    parameter int MASK_W     = 8,
    parameter int CNT_W      = 14,
    parameter int HALF_DEPTH = 64,
    parameter int MIN_CNT    = 16,
    localparam int HALF_AW   = $clog2(HALF_DEPTH),
    localparam int RAM_AW    = HALF_AW + 1,
    localparam int ENTRY_W   = CNT_W + MASK_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               glb_en,
    input  logic               port_en,
    input  logic               single_buf,
    input  logic               buf_sel,
    input  logic               wr_en,
    input  logic [RAM_AW-1:0]  wr_addr,
    input  logic [ENTRY_W-1:0] wr_data,
    input  logic               unit_tick,
    input  logic               cyc_start,
    output logic [MASK_W-1:0]  allow_mask,
    output logic               active_buf,
    output logic               err_count,
    output logic               err_addr
);

    logic [RAM_AW-1:0]  rd_addr;
    logic [ENTRY_W-1:0] rd_data;
    logic               swap, next_half, enable;

    assign enable = glb_en && port_en;

    tgs_cmd_ram #(
        .ENTRY_W   (ENTRY_W),
        .HALF_DEPTH(HALF_DEPTH),
        .HALF_AW   (HALF_AW),
        .RAM_AW    (RAM_AW)
    ) u_ram (
        .clk    (clk),
        .wr_en  (wr_en),
        .wr_addr(wr_addr),
        .wr_data(wr_data),
        .rd_addr(rd_addr),
        .rd_data(rd_data)
    );

    tgs_buf_ctrl u_buf (
        .clk       (clk),
        .rst_n     (rst_n),
        .single_buf(single_buf),
        .buf_sel   (buf_sel),
        .swap      (swap),
        .next_half (next_half),
        .active_buf(active_buf)
    );

    tgs_seq_fsm #(
        .MASK_W    (MASK_W),
        .CNT_W     (CNT_W),
        .HALF_DEPTH(HALF_DEPTH),
        .MIN_CNT   (MIN_CNT),
        .HALF_AW   (HALF_AW),
        .RAM_AW    (RAM_AW),
        .ENTRY_W   (ENTRY_W)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (enable),
        .cyc_start  (cyc_start),
        .unit_tick  (unit_tick),
        .next_half  (next_half),
        .active_half(active_buf),
        .rd_data    (rd_data),
        .rd_addr    (rd_addr),
        .swap       (swap),
        .allow_mask (allow_mask),
        .err_count  (err_count),
        .err_addr   (err_addr)
    );

endmodule

// File: rtl/tgs_checker.sv
module tgs_checker #(
    parameter int MASK_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              glb_en,
    input logic              port_en,
    input logic              single_buf,
    input logic              unit_tick,
    input logic              cyc_start,
    input logic [MASK_W-1:0] allow_mask,
    input logic              active_buf,
    input logic              err_count,
    input logic              err_addr
);

    logic en;
    assign en = glb_en && port_en;

    // R2: one cycle after any enable is low the mask is fully open
    assert_off_open_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(en)) |-> (allow_mask == '1));

    // R4: without a tick or a cycle start the mask does not move
    assert_mask_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && en && $past(en) && !$past(unit_tick) && !$past(cyc_start))
        |-> $stable(allow_mask));

    // R7: the active half only changes after a cycle-start pulse
    assert_buf_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(cyc_start)) |-> $stable(active_buf));

    // R8: one-buffer mode always runs half 0
    assert_single_half_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && cyc_start && single_buf && en && $past(en)) |=> !active_buf);

    // R9: the address-error flag is sticky
    assert_err_addr_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        err_addr |=> err_addr);

    // R10: the count-error flag is sticky
    assert_err_count_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        err_count |=> err_count);

endmodule

bind tx_gate_sequencer tgs_checker #(.MASK_W(MASK_W)) u_tgs_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .glb_en    (glb_en),
    .port_en   (port_en),
    .single_buf(single_buf),
    .unit_tick (unit_tick),
    .cyc_start (cyc_start),
    .allow_mask(allow_mask),
    .active_buf(active_buf),
    .err_count (err_count),
    .err_addr  (err_addr)
);

// File: tb/test_tx_gate_sequencer.sv
module test_tx_gate_sequencer;

    localparam int CLK_PERIOD = 10;
    localparam int HALF_DEPTH = 8;
    localparam int HALF_AW    = $clog2(HALF_DEPTH);

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        glb_en = 1'b0, port_en = 1'b0, single_buf = 1'b0, buf_sel = 1'b0;
    logic        wr_en = 1'b0;
    logic [HALF_AW:0] wr_addr = '0;
    logic [21:0] wr_data = '0;
    logic        unit_tick = 1'b0, cyc_start = 1'b0;
    logic [7:0]  allow_mask;
    logic        active_buf, err_count, err_addr;

    int n_checks = 0;
    int n_errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tx_gate_sequencer #(.HALF_DEPTH(HALF_DEPTH)) i_tx_gate_sequencer (
        .clk(clk), .rst_n(rst_n), .glb_en(glb_en), .port_en(port_en),
        .single_buf(single_buf), .buf_sel(buf_sel), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .unit_tick(unit_tick),
        .cyc_start(cyc_start), .allow_mask(allow_mask), .active_buf(active_buf),
        .err_count(err_count), .err_addr(err_addr)
    );

    task automatic check(string req, int act, int exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; glb_en = 1'b0; port_en = 1'b0;
        single_buf = 1'b0; buf_sel = 1'b0; unit_tick = 1'b0; cyc_start = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic write_cmd(int half, int idx, int cnt, int mask);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_addr = {1'(half), HALF_AW'(idx)};
        wr_data = {14'(cnt), 8'(mask)};
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic enable_on();
        @(negedge clk);
        glb_en = 1'b1; port_en = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic pulse_start();
        @(negedge clk);
        cyc_start = 1'b1;
        @(negedge clk);
        cyc_start = 1'b0;
    endtask

    task automatic ticks(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            unit_tick = 1'b1;
            @(negedge clk);
            unit_tick = 1'b0;
        end
    endtask

    task automatic t_reset_and_disabled();
        do_reset();
        check("R2 reset mask", allow_mask, 8'hFF);
        check("R7 reset active_buf", active_buf, 0);
        check("R9 reset err_addr", err_addr, 0);
        check("R10 reset err_count", err_count, 0);
        write_cmd(0, 0, 0, 8'h3C);
        pulse_start();
        check("R2 start while disabled", allow_mask, 8'hFF);
        enable_on();
        check("R2 armed mask", allow_mask, 8'hFF);
    endtask

    task automatic t_basic_list();
        do_reset();
        write_cmd(0, 0, 20, 8'h01);
        write_cmd(0, 1, 16, 8'h02);
        write_cmd(0, 2, 0, 8'h04);
        enable_on();
        pulse_start();
        check("R1 R3 word0 mask", allow_mask, 8'h01);
        repeat (5) @(negedge clk);
        check("R4 no tick holds", allow_mask, 8'h01);
        ticks(19);
        check("R4 before expiry", allow_mask, 8'h01);
        ticks(1);
        check("R4 after 20 ticks", allow_mask, 8'h02);
        ticks(15);
        check("R4 second word held", allow_mask, 8'h02);
        ticks(1);
        check("R6 end word mask", allow_mask, 8'h04);
        ticks(40);
        check("R6 end mask held", allow_mask, 8'h04);
        pulse_start();
        check("R3 restart word0", allow_mask, 8'h01);
        check("R10 no error from end", err_count, 0);
        @(negedge clk);
        port_en = 1'b0;
        @(negedge clk);
        check("R2 disable mid-list", allow_mask, 8'hFF);
    endtask

    task automatic t_min_count();
        do_reset();
        write_cmd(0, 0, 3, 8'h10);
        write_cmd(0, 1, 0, 8'h20);
        enable_on();
        pulse_start();
        ticks(15);
        check("R5 clamped count held", allow_mask, 8'h10);
        ticks(1);
        check("R5 advance at 16", allow_mask, 8'h20);
    endtask

    task automatic t_early_restart();
        do_reset();
        write_cmd(0, 0, 100, 8'h0F);
        write_cmd(0, 1, 0, 8'hF0);
        enable_on();
        pulse_start();
        ticks(10);
        check("R10 no error yet", err_count, 0);
        pulse_start();
        check("R10 err_count set", err_count, 1);
        check("R10 list restarted", allow_mask, 8'h0F);
        ticks(99);
        check("R10 full count reloaded", allow_mask, 8'h0F);
        ticks(1);
        check("R10 advance after reload", allow_mask, 8'hF0);
    endtask

    task automatic t_buffers();
        do_reset();
        write_cmd(0, 0, 0, 8'h55);
        write_cmd(1, 0, 0, 8'hAA);
        enable_on();
        pulse_start();
        check("R1 half0 word", allow_mask, 8'h55);
        check("R7 active half0", active_buf, 0);
        @(negedge clk);
        buf_sel = 1'b1;
        ticks(5);
        check("R7 select deferred", active_buf, 0);
        check("R7 mask unchanged", allow_mask, 8'h55);
        pulse_start();
        check("R1 R7 half1 word", allow_mask, 8'hAA);
        check("R7 active half1", active_buf, 1);
        @(negedge clk);
        single_buf = 1'b1;
        pulse_start();
        check("R8 single mode mask", allow_mask, 8'h55);
        check("R8 single mode status", active_buf, 0);
    endtask

    task automatic t_overrun();
        do_reset();
        for (int i = 0; i < HALF_DEPTH; i++) write_cmd(0, i, 16, 1 << i);
        enable_on();
        pulse_start();
        ticks(16 * HALF_DEPTH - 1);
        check("R9 last word mask", allow_mask, 1 << (HALF_DEPTH - 1));
        check("R9 no error yet", err_addr, 0);
        ticks(1);
        check("R9 err_addr set", err_addr, 1);
        check("R9 last mask held", allow_mask, 1 << (HALF_DEPTH - 1));
        ticks(20);
        check("R9 held after ticks", allow_mask, 1 << (HALF_DEPTH - 1));
        pulse_start();
        check("R10 no error from overrun", err_count, 0);
        check("R9 flag sticky", err_addr, 1);
        check("R9 restart mask", allow_mask, 8'h01);
    endtask

    task automatic t_priority();
        do_reset();
        write_cmd(0, 0, 16, 8'h01);
        write_cmd(0, 1, 0, 8'h02);
        enable_on();
        pulse_start();
        ticks(15);
        @(negedge clk);
        unit_tick = 1'b1; cyc_start = 1'b1;
        @(negedge clk);
        unit_tick = 1'b0; cyc_start = 1'b0;
        check("R11 start wins", allow_mask, 8'h01);
        check("R11 count error", err_count, 1);
        ticks(15);
        check("R11 tick not counted", allow_mask, 8'h01);
        ticks(1);
        check("R11 advance after 16", allow_mask, 8'h02);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        t_reset_and_disabled();
        t_basic_list();
        t_min_count();
        t_early_restart();
        t_buffers();
        t_overrun();
        t_priority();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule